// File: doc/BRIEF.md
# Suspect-Set Fault Isolation Engine

This block narrows down which one of `N_RES` logic resources is faulty. It keeps a bitmask of resources that are still under suspicion. Bit *i* stands for resource *i*. At reset every resource is a suspect.

Each pairwise comparison is presented with a one-cycle strobe. The strobe carries three things: the resource-usage masks of the two configurations that were compared (the two use disjoint resources), a discrepancy bit, and a mode bit. The mode bit says whether the fault under search is always visible at the outputs or only now and then. The engine then updates the mask as follows:

- A discrepancy intersects the mask with the union of the two usage masks.
- In the always-visible mode, an agreement clears the resources it used.
- In the intermittent mode, an agreement leaves the mask as it is.

The engine reports the mask, its population count, the lowest suspect index, and a done flag once a single suspect remains. It also keeps a saturating count of comparisons. An update that would empty the mask is refused, and a sticky inconsistency flag is raised instead. Choosing the partitions is left to the caller.

Top module: `fault_isolator`

## Requirements
- R1: After reset, `suspect_o` is all ones, `pop_o` equals `N_RES`, `count_o` is 0, and `done_o` and `incons_o` are 0.
- R2: A strobe with `mismatch_i`=1 replaces the mask with mask AND (`use_a_i` OR `use_b_i`) on the next clock edge, in either mode.
- R3: A strobe with `mismatch_i`=0 and `mode_i`=0 (always-visible mode) replaces the mask with mask AND NOT (`use_a_i` OR `use_b_i`).
- R4: A strobe with `mismatch_i`=0 and `mode_i`=1 (intermittent mode) leaves the mask unchanged.
- R5: If the update from R2 or R3 would produce an all-zero mask, the mask keeps its previous value and `incons_o` goes to 1. `incons_o` then stays at 1 until reset.
- R6: `pop_o` always equals the number of ones in `suspect_o`.
- R7: `index_o` is the position of the lowest set bit of `suspect_o` (bit 0 is resource 0). `done_o` is 1 exactly when `pop_o` equals 1.
- R8: Each strobe increments `count_o` by one, and `count_o` saturates at 2^`CNT_W`-1.
- R9: While `cmp_valid_i` is 0, `suspect_o` and `count_o` do not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | One comparison result is presented this cycle |
| mode_i | input | 1 | 0 = fault always visible, 1 = intermittent |
| use_a_i | input | N_RES | Resources used by the first configuration |
| use_b_i | input | N_RES | Resources used by the second configuration |
| mismatch_i | input | 1 | The two outputs disagreed |
| suspect_o | output | N_RES | Current suspect mask |
| pop_o | output | $clog2(N_RES+1) | Number of suspects |
| index_o | output | $clog2(N_RES) | Lowest suspect index |
| done_o | output | 1 | Exactly one suspect remains |
| count_o | output | CNT_W | Comparisons processed, saturating |
| incons_o | output | 1 | An update was refused because it would empty the mask |

## Verification
Isolation being complete and the empty-set guard can both act in the same cycle. This happens when a discrepancy arrives after only one suspect remains and its usage masks exclude that suspect. The bench provokes this by first isolating resource 12 and then strobing a discrepancy over resources 1 and 2. It judges the result by requiring that the mask, the index and `done_o` are unchanged while `incons_o` rises and the count still advances.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic {
    FI_ALWAYS   = 1'b0,
    FI_INTERMIT = 1'b1
  } fi_mode_e;
endpackage

// File: rtl/fi_update.sv
module fi_update
  import fi_pkg::*;
#(
  parameter int N_RES = 16
) (
  input  logic [N_RES-1:0] suspect_i,
  input  logic [N_RES-1:0] use_a_i,
  input  logic [N_RES-1:0] use_b_i,
  input  logic             mismatch_i,
  input  logic             mode_i,
  output logic [N_RES-1:0] next_o,
  output logic             empty_o
);
  logic [N_RES-1:0] used;
  logic [N_RES-1:0] cand;

  always_comb begin
    used = use_a_i | use_b_i;
    cand = suspect_i;
    if (mismatch_i) begin
      cand = suspect_i & used;
    end else if (mode_i == FI_ALWAYS) begin
      // agreement exonerates everything the pair touched
      cand = suspect_i & ~used;
    end
    empty_o = (cand == '0);
    next_o  = empty_o ? suspect_i : cand;
  end
endmodule

// File: rtl/fi_popcount.sv
module fi_popcount #(
  parameter int N_RES = 16,
  localparam int POP_W = $clog2(N_RES + 1)
) (
  input  logic [N_RES-1:0] mask_i,
  output logic [POP_W-1:0] pop_o
);
  always_comb begin
    pop_o = '0;
    for (int i = 0; i < N_RES; i++) begin
      pop_o = pop_o + POP_W'(mask_i[i]);
    end
  end
endmodule

// File: rtl/fi_lowest.sv
module fi_lowest #(
  parameter int N_RES = 16,
  localparam int IDX_W = $clog2(N_RES)
) (
  input  logic [N_RES-1:0] mask_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N_RES - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fault_isolator.sv
module fault_isolator #(
  parameter int N_RES = 16,
  parameter int CNT_W = 8,
  localparam int POP_W = $clog2(N_RES + 1),
  localparam int IDX_W = $clog2(N_RES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic             mode_i,
  input  logic [N_RES-1:0] use_a_i,
  input  logic [N_RES-1:0] use_b_i,
  input  logic             mismatch_i,
  output logic [N_RES-1:0] suspect_o,
  output logic [POP_W-1:0] pop_o,
  output logic [IDX_W-1:0] index_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             incons_o
);
  logic [N_RES-1:0] suspect_q, suspect_d;
  logic [CNT_W-1:0] count_q;
  logic             incons_q;
  logic             empty;

  fi_update #(.N_RES(N_RES)) i_update (
    .suspect_i (suspect_q),
    .use_a_i   (use_a_i),
    .use_b_i   (use_b_i),
    .mismatch_i(mismatch_i),
    .mode_i    (mode_i),
    .next_o    (suspect_d),
    .empty_o   (empty)
  );

  fi_popcount #(.N_RES(N_RES)) i_pop (
    .mask_i(suspect_q),
    .pop_o (pop_o)
  );

  fi_lowest #(.N_RES(N_RES)) i_low (
    .mask_i(suspect_q),
    .idx_o (index_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      suspect_q <= '1;
      count_q   <= '0;
      incons_q  <= 1'b0;
    end else if (cmp_valid_i) begin
      suspect_q <= suspect_d;
      if (count_q != '1) count_q <= count_q + 1'b1;
      if (empty) incons_q <= 1'b1;
    end
  end

  assign suspect_o = suspect_q;
  assign count_o   = count_q;
  assign incons_o  = incons_q;
  assign done_o    = (pop_o == POP_W'(1));
endmodule

// File: rtl/fi_checker.sv
module fi_checker #(
  parameter int N_RES = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(N_RES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_valid_i,
  input logic             mode_i,
  input logic             mismatch_i,
  input logic [N_RES-1:0] suspect_o,
  input logic [IDX_W-1:0] index_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o,
  input logic             incons_o
);
  // R5
  never_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspect_o != '0);

  // R2
  shrink_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> ((suspect_o & ~$past(suspect_o)) == '0));

  // R4
  intermit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && mode_i && !mismatch_i) |=> $stable(suspect_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> ($stable(suspect_o) && $stable(count_o)));

  // R5
  incons_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    incons_o |=> incons_o);

  // R7
  done_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($onehot0(suspect_o) && suspect_o[index_o]));

  // R8
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && count_o != '1) |=> (count_o == $past(count_o) + 1'b1));
endmodule

bind fault_isolator fi_checker #(.N_RES(N_RES), .CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmp_valid_i(cmp_valid_i),
  .mode_i     (mode_i),
  .mismatch_i (mismatch_i),
  .suspect_o  (suspect_o),
  .index_o    (index_o),
  .done_o     (done_o),
  .count_o    (count_o),
  .incons_o   (incons_o)
);

// File: tb/test_fault_isolator.sv
module test_fault_isolator;
  localparam int N = 16;
  localparam int CW = 8;
  localparam int PW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, mode = 1'b0, mis = 1'b0;
  logic [N-1:0] ua = '0, ub = '0;
  logic [N-1:0] sus;
  logic [PW-1:0] pop;
  logic [IW-1:0] idx;
  logic done, incons;
  logic [CW-1:0] cnt;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  fault_isolator #(.N_RES(N), .CNT_W(CW)) i_fault_isolator (
    .clk_i(clk), .rst_ni(rst_n), .cmp_valid_i(valid), .mode_i(mode),
    .use_a_i(ua), .use_b_i(ub), .mismatch_i(mis),
    .suspect_o(sus), .pop_o(pop), .index_o(idx), .done_o(done),
    .count_o(cnt), .incons_o(incons)
  );

  // {mode, mismatch, use_a, use_b, expected mask, expected incons}
  localparam logic [50:0] VEC [6] = '{
    {1'b0, 1'b0, 16'h000F, 16'h00F0, 16'hFF00, 1'b0},  // R3
    {1'b1, 1'b0, 16'h0F00, 16'h0000, 16'hFF00, 1'b0},  // R4
    {1'b1, 1'b1, 16'h3000, 16'h0C00, 16'h3C00, 1'b0},  // R2
    {1'b0, 1'b1, 16'h0400, 16'h1000, 16'h1400, 1'b0},  // R2
    {1'b0, 1'b0, 16'h0400, 16'h0001, 16'h1000, 1'b0},  // R3, R7
    {1'b1, 1'b1, 16'h0002, 16'h0004, 16'h1000, 1'b1}   // R5 with done
  };

  function automatic int ones(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  function automatic int low(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic m, input logic d, input logic [N-1:0] a,
                        input logic [N-1:0] b);
    @(negedge clk);
    mode = m; mis = d; ua = a; ub = b; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic derived(input string tag);
    chk({tag, " R6 pop"}, pop, ones(sus));
    chk({tag, " R7 index"}, idx, low(sus));
    chk({tag, " R7 done"}, done, ones(sus) == 1);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 mask", sus, {N{1'b1}});
    chk("R1 pop", pop, N);
    chk("R1 count", cnt, 0);
    chk("R1 done", done, 0);
    chk("R1 incons", incons, 0);

    for (int k = 0; k < 6; k++) begin
      strobe(VEC[k][50], VEC[k][49], VEC[k][48:33], VEC[k][32:17]);
      chk($sformatf("R2/R3/R4 vec%0d mask", k), sus, VEC[k][16:1]);
      chk($sformatf("R5 vec%0d incons", k), incons, VEC[k][0]);
      chk($sformatf("R8 vec%0d count", k), cnt, k + 1);
      derived($sformatf("vec%0d", k));
    end
    chk("R7 isolated index 12", idx, 12);

    // R9: inputs toggle with no strobe
    @(negedge clk);
    mode = 1'b0; mis = 1'b0; ua = '1; ub = '1;
    repeat (3) @(negedge clk);
    chk("R9 mask idle", sus, 16'h1000);
    chk("R9 count idle", cnt, 6);

    // R5: agreement over everything in always mode
    do_reset();
    strobe(1'b0, 1'b0, 16'hFF00, 16'h00FF);
    chk("R5 mask kept", sus, {N{1'b1}});
    chk("R5 incons set", incons, 1);
    strobe(1'b1, 1'b1, 16'h0003, 16'h0000);
    chk("R5 incons sticky", incons, 1);
    chk("R2 after guard", sus, 16'h0003);
    derived("guard");

    // R8 saturation
    do_reset();
    for (int k = 0; k < 300; k++) strobe(1'b1, 1'b0, '0, '0);
    chk("R8 saturate", cnt, (1 << CW) - 1);
    chk("R4 unchanged", sus, {N{1'b1}});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule